// File: doc/BRIEF.md
# External Bus Strobe Timing Generator

This block times one access to an asynchronous external memory on a chip-select bus. A start request is taken only while the block is idle. The direction, page/normal selection, multiplexed address/data enable, target chip select, active byte lanes and every wait field are latched in that cycle. A single step counter then walks through the access.

The main phase is followed by a tail phase. In the main phase, the chip select, the read strobe, the two byte-lane write strobes, the write-data output enable and the address-latch phase each switch on at their own programmed step. In the tail phase, the chip select and the write data may stay active for extra cycles after the strobes are released. A one-cycle done pulse marks the end of the access.

The latched fields are checked against the ordering rules a correct program must satisfy. A violation raises a flag for that access. Each assert delay is also limited to the total wait, so every strobe still shows for at least one step.

Top module: `bus_strobe_gen`

## Requirements
- R1: While reset is held and right after it, all chip selects (`cs_n`, 4'hF), `rd_n` and both `wr_n` bits are high, and `wd_oe`, `ale`, `done` and `config_error` are low.
- R2: A start taken while idle begins an access. Step k of the access shows at the outputs in the cycle after the (k+1)-th clock edge following acceptance. The chip-select line numbered by `cs_sel` (binary, bit i of `cs_n` for value i) goes low from step `cs_wait` to the last main step, then for `cs_hold` more steps. All other chip-select lines stay high.
- R3: For a read (`is_write`=0), `rd_n` is low from step `rd_wait` to the last main step. It is never low during a write.
- R4: For a write, `wr_n[i]` is low from step `wr_wait` to the last main step when `lane_en[i]` is 1. Both bits stay high during a read.
- R5: For a write, `wd_oe` is high from step `wd_wait` to the last main step, then for `wd_hold` more steps. It is never high during a read.
- R6: With `mux_mode`=1, `ale` is high on steps 0 to `addr_wait`+1 that lie in the main phase. With `mux_mode`=0, `ale` stays low.
- R7: The main phase has T+1 steps, 0 to T. T is chosen by direction and `page_mode`: normal read uses `tot_rd`, normal write uses `tot_wr`, page read uses `tot_page_rd` (all 5-bit), and page write uses the 3-bit `tot_page_wr`. The tail has `cs_hold` steps for a read and max(`cs_hold`,`wd_hold`) steps for a write.
- R8: `config_error` is set at acceptance and held until the next acceptance. It is set if any of these holds: `cs_hold` > `wd_hold`. For a read: `cs_wait` > `rd_wait` or `rd_wait` > T. For a write: `cs_wait` > `wr_wait`, `wd_wait` > `wr_wait`, or `wr_wait` > T. In multiplexed mode, also: `cs_wait` > `addr_wait`, or `addr_wait`+2 above the strobe wait of the access (for a write, also above `wd_wait`).
- R9: Each of `cs_wait`, `rd_wait`, `wr_wait` and `wd_wait` that exceeds T is used as T.
- R10: `done` is high for exactly one cycle, the cycle after the last tail step is shown. In that cycle all strobes are inactive.
- R11: A start during an access is ignored. Input changes after acceptance do not alter the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Access request, taken only while idle |
| is_write | input | 1 | 1 = write access, 0 = read access |
| page_mode | input | 1 | 1 = page access totals, 0 = normal totals |
| mux_mode | input | 1 | Multiplexed address/data phase enable |
| cs_sel | input | 2 | Binary index of the chip select to drive |
| lane_en | input | 2 | Byte lanes whose write strobe is used |
| cs_wait | input | 3 | Step at which chip select asserts |
| rd_wait | input | 3 | Step at which the read strobe asserts |
| wr_wait | input | 3 | Step at which the write strobes assert |
| wd_wait | input | 3 | Step at which write data is driven |
| cs_hold | input | 3 | Extra tail steps for chip select |
| wd_hold | input | 3 | Extra tail steps for write data |
| addr_wait | input | 2 | Extra address-phase steps in multiplexed mode |
| tot_rd | input | 5 | Total wait, normal read |
| tot_wr | input | 5 | Total wait, normal write |
| tot_page_rd | input | 5 | Total wait, page read |
| tot_page_wr | input | 3 | Total wait, page write |
| cs_n | output | 4 | Active-low chip selects |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 2 | Active-low byte-lane write strobes |
| wd_oe | output | 1 | Write-data output enable |
| ale | output | 1 | Address phase indicator |
| done | output | 1 | One-cycle end-of-access pulse |
| config_error | output | 1 | Ordering-rule violation in the current access |

## Verification
The done pulse of one access and the acceptance of the next access can fall in the same cycle. This is provoked by raising start in the cycle that shows the final tail step, so that start is sampled on the edge where the block returns to idle. The bench then expects done high with every strobe inactive in the following cycle, a fresh `config_error` for the new fields, and the new access's step 0 one cycle later with no step lost or repeated. A start raised in the middle of an access, with scrambled fields, is also checked to leave the running waveform untouched.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;
  localparam int NUM_CS   = 4;
  localparam int CS_SEL_W = $clog2(NUM_CS);
  localparam int LANES    = 2;
  localparam int DLY_W    = 3;
  localparam int TOT_W    = 5;
  localparam int PWT_W    = 3;
  localparam int ADR_W    = 2;
  localparam int STEP_W   = TOT_W + 1;

  typedef struct packed {
    logic                is_wr;
    logic                mux;
    logic [CS_SEL_W-1:0] sel;
    logic [LANES-1:0]    lanes;
    logic [TOT_W-1:0]    total;
    logic [DLY_W-1:0]    cs_d;
    logic [DLY_W-1:0]    rd_d;
    logic [DLY_W-1:0]    wr_d;
    logic [DLY_W-1:0]    wd_d;
    logic [DLY_W-1:0]    cs_x;
    logic [DLY_W-1:0]    wd_x;
    logic [ADR_W-1:0]    aw;
  } acc_cfg_t;

  // total wait picked by direction and page selection
  function automatic logic [TOT_W-1:0] pick_total(
    input logic wr, input logic page,
    input logic [TOT_W-1:0] nrd, input logic [TOT_W-1:0] nwr,
    input logic [TOT_W-1:0] prd, input logic [PWT_W-1:0] pwr);
    if (page) return wr ? TOT_W'(pwr) : prd;
    return wr ? nwr : nrd;
  endfunction

  // an assert delay never runs past the total wait
  function automatic logic [DLY_W-1:0] clamp_dly(
    input logic [DLY_W-1:0] d, input logic [TOT_W-1:0] t);
    return (TOT_W'(d) > t) ? DLY_W'(t) : d;
  endfunction

  function automatic logic [DLY_W-1:0] tail_len(
    input logic wr, input logic [DLY_W-1:0] cx, input logic [DLY_W-1:0] wx);
    return (wr && (wx > cx)) ? wx : cx;
  endfunction

  function automatic logic order_bad(
    input logic wr, input logic mux,
    input logic [DLY_W-1:0] cs, input logic [DLY_W-1:0] rd,
    input logic [DLY_W-1:0] wrd, input logic [DLY_W-1:0] wd,
    input logic [DLY_W-1:0] cx, input logic [DLY_W-1:0] wx,
    input logic [ADR_W-1:0] aw, input logic [TOT_W-1:0] t);
    int  lo;
    logic bad;
    lo  = int'(aw) + 2;
    bad = (cx > wx);
    if (wr) bad = bad | (cs > wrd) | (wd > wrd) | (TOT_W'(wrd) > t);
    else    bad = bad | (cs > rd) | (TOT_W'(rd) > t);
    if (mux) begin
      bad = bad | (int'(cs) > int'(aw));
      if (wr) bad = bad | (lo > int'(wrd)) | (lo > int'(wd));
      else    bad = bad | (lo > int'(rd));
    end
    return bad;
  endfunction
endpackage

// File: rtl/strobe_cfg_cap.sv
module strobe_cfg_cap
  import bus_strobe_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                is_write,
  input  logic                page_mode,
  input  logic                mux_mode,
  input  logic [CS_SEL_W-1:0] cs_sel,
  input  logic [LANES-1:0]    lane_en,
  input  logic [DLY_W-1:0]    cs_wait,
  input  logic [DLY_W-1:0]    rd_wait,
  input  logic [DLY_W-1:0]    wr_wait,
  input  logic [DLY_W-1:0]    wd_wait,
  input  logic [DLY_W-1:0]    cs_hold,
  input  logic [DLY_W-1:0]    wd_hold,
  input  logic [ADR_W-1:0]    addr_wait,
  input  logic [TOT_W-1:0]    tot_rd,
  input  logic [TOT_W-1:0]    tot_wr,
  input  logic [TOT_W-1:0]    tot_page_rd,
  input  logic [PWT_W-1:0]    tot_page_wr,
  output acc_cfg_t            cfg_q,
  output logic                err_q
);
  logic [TOT_W-1:0] t_sel;
  logic             bad_now;

  assign t_sel   = pick_total(is_write, page_mode, tot_rd, tot_wr, tot_page_rd, tot_page_wr);
  assign bad_now = order_bad(is_write, mux_mode, cs_wait, rd_wait, wr_wait, wd_wait,
                             cs_hold, wd_hold, addr_wait, t_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else if (accept) begin
      cfg_q.is_wr <= is_write;
      cfg_q.mux   <= mux_mode;
      cfg_q.sel   <= cs_sel;
      cfg_q.lanes <= lane_en;
      cfg_q.total <= t_sel;
      cfg_q.cs_d  <= clamp_dly(cs_wait, t_sel);
      cfg_q.rd_d  <= clamp_dly(rd_wait, t_sel);
      cfg_q.wr_d  <= clamp_dly(wr_wait, t_sel);
      cfg_q.wd_d  <= clamp_dly(wd_wait, t_sel);
      cfg_q.cs_x  <= cs_hold;
      cfg_q.wd_x  <= wd_hold;
      cfg_q.aw    <= addr_wait;
      err_q       <= bad_now;
    end
  end

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(err_q));
  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(cfg_q));
endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
  import bus_strobe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STEP_W-1:0] end_step,
  output logic              accept,
  output logic              running,
  output logic              last,
  output logic [STEP_W-1:0] step
);
  assign accept = start && !running;
  assign last   = running && (step == end_step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      step    <= '0;
    end else if (accept) begin
      running <= 1'b1;
      step    <= '0;
    end else if (running) begin
      if (last) running <= 1'b0;
      else      step    <= step + 1'b1;
    end
  end

  // R11
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !last) |=> (running && step == $past(step) + 1'b1));
  // R7
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !running);
endmodule

// File: rtl/strobe_drive.sv
module strobe_drive
  import bus_strobe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic              last,
  input  logic [STEP_W-1:0] step,
  input  acc_cfg_t          cfg_q,
  input  logic              err_q,
  output logic [NUM_CS-1:0] cs_n,
  output logic              rd_n,
  output logic [LANES-1:0]  wr_n,
  output logic              wd_oe,
  output logic              ale,
  output logic              done
);
  logic [STEP_W-1:0] tot_s, over;
  logic              in_main, cs_on, rd_on, wr_on, wd_on, ale_on, fin_q;
  logic [NUM_CS-1:0] cs_vec;
  logic [LANES-1:0]  wr_vec;

  assign tot_s   = STEP_W'(cfg_q.total);
  assign in_main = step <= tot_s;
  assign over    = step - tot_s;
  assign cs_on   = running && (step >= STEP_W'(cfg_q.cs_d)) &&
                   (in_main || over <= STEP_W'(cfg_q.cs_x));
  assign rd_on   = running && !cfg_q.is_wr && in_main && (step >= STEP_W'(cfg_q.rd_d));
  assign wr_on   = running && cfg_q.is_wr && in_main && (step >= STEP_W'(cfg_q.wr_d));
  assign wd_on   = running && cfg_q.is_wr && (step >= STEP_W'(cfg_q.wd_d)) &&
                   (in_main || over <= STEP_W'(cfg_q.wd_x));
  assign ale_on  = running && cfg_q.mux && in_main &&
                   (step < STEP_W'(cfg_q.aw) + STEP_W'(2));

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_vec[i] = cs_on && (cfg_q.sel == CS_SEL_W'(i));
  end
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign wr_vec[j] = wr_on && cfg_q.lanes[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n  <= '1;
      rd_n  <= 1'b1;
      wr_n  <= '1;
      wd_oe <= 1'b0;
      ale   <= 1'b0;
      fin_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      cs_n  <= ~cs_vec;
      rd_n  <= ~rd_on;
      wr_n  <= ~wr_vec;
      wd_oe <= wd_on;
      ale   <= ale_on;
      fin_q <= last;
      done  <= fin_q;
    end
  end

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R3
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (wr_n == '1) && !wd_oe);
  // R4
  wr_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_q && wr_n != '1) |-> (cs_n != '1));
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n == '1) && rd_n && (wr_n == '1) && !wd_oe && !ale);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_strobe_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                is_write,
  input  logic                page_mode,
  input  logic                mux_mode,
  input  logic [CS_SEL_W-1:0] cs_sel,
  input  logic [LANES-1:0]    lane_en,
  input  logic [DLY_W-1:0]    cs_wait,
  input  logic [DLY_W-1:0]    rd_wait,
  input  logic [DLY_W-1:0]    wr_wait,
  input  logic [DLY_W-1:0]    wd_wait,
  input  logic [DLY_W-1:0]    cs_hold,
  input  logic [DLY_W-1:0]    wd_hold,
  input  logic [ADR_W-1:0]    addr_wait,
  input  logic [TOT_W-1:0]    tot_rd,
  input  logic [TOT_W-1:0]    tot_wr,
  input  logic [TOT_W-1:0]    tot_page_rd,
  input  logic [PWT_W-1:0]    tot_page_wr,
  output logic [NUM_CS-1:0]   cs_n,
  output logic                rd_n,
  output logic [LANES-1:0]    wr_n,
  output logic                wd_oe,
  output logic                ale,
  output logic                done,
  output logic                config_error
);
  acc_cfg_t          cfg_q;
  logic              accept, running, last;
  logic [STEP_W-1:0] step, end_step;

  assign end_step = STEP_W'(cfg_q.total) +
                    STEP_W'(tail_len(cfg_q.is_wr, cfg_q.cs_x, cfg_q.wd_x));

  strobe_cfg_cap u_cap (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .is_write(is_write), .page_mode(page_mode), .mux_mode(mux_mode),
    .cs_sel(cs_sel), .lane_en(lane_en),
    .cs_wait(cs_wait), .rd_wait(rd_wait), .wr_wait(wr_wait), .wd_wait(wd_wait),
    .cs_hold(cs_hold), .wd_hold(wd_hold), .addr_wait(addr_wait),
    .tot_rd(tot_rd), .tot_wr(tot_wr), .tot_page_rd(tot_page_rd),
    .tot_page_wr(tot_page_wr), .cfg_q(cfg_q), .err_q(config_error)
  );

  strobe_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .end_step(end_step),
    .accept(accept), .running(running), .last(last), .step(step)
  );

  strobe_drive u_drv (
    .clk(clk), .rst_n(rst_n), .running(running), .last(last), .step(step),
    .cfg_q(cfg_q), .err_q(config_error),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .wd_oe(wd_oe), .ale(ale), .done(done)
  );
endmodule

// File: tb/sim_bus_strobe_gen.sv
module sim_bus_strobe_gen;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic is_write, page_mode, mux_mode;
  logic [1:0] cs_sel, lane_en, addr_wait;
  logic [2:0] cs_wait, rd_wait, wr_wait, wd_wait, cs_hold, wd_hold, tot_page_wr;
  logic [4:0] tot_rd, tot_wr, tot_page_rd;
  logic [3:0] cs_n;
  logic rd_n, wd_oe, ale, done, config_error;
  logic [1:0] wr_n;

  int n_chk = 0, n_fail = 0;
  int g_wr, g_page, g_mux, g_sel, g_lanes, g_cs, g_rd, g_wrd, g_wd, g_cx, g_wx, g_aw;
  int g_trd, g_twr, g_tprd, g_tpwr;
  bit pending = 0;

  always #4 clk = ~clk;

  bus_strobe_gen u0 (.*);

  function automatic int imin(int a, int b); return (a < b) ? a : b; endfunction
  function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction

  function automatic int e_total();
    case ({g_page[0], g_wr[0]})
      2'b00: return g_trd;
      2'b01: return g_twr;
      2'b10: return g_tprd;
      default: return g_tpwr;
    endcase
  endfunction

  function automatic bit e_err();
    int t = e_total();
    int strobe = g_wr ? g_wrd : g_rd;
    bit e = 0;
    if (g_cx > g_wx) e = 1;
    if (g_cs > strobe || strobe > t) e = 1;
    if (g_wr && g_wd > g_wrd) e = 1;
    if (g_mux && (g_cs > g_aw || g_aw + 2 > strobe || (g_wr && g_aw + 2 > g_wd))) e = 1;
    return e;
  endfunction

  function automatic int e_steps();
    return e_total() + 1 + (g_wr ? imax(g_cx, g_wx) : g_cx);
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic drive_cfg();
    is_write = g_wr[0]; page_mode = g_page[0]; mux_mode = g_mux[0];
    cs_sel = g_sel[1:0]; lane_en = g_lanes[1:0]; addr_wait = g_aw[1:0];
    cs_wait = g_cs[2:0]; rd_wait = g_rd[2:0]; wr_wait = g_wrd[2:0]; wd_wait = g_wd[2:0];
    cs_hold = g_cx[2:0]; wd_hold = g_wx[2:0];
    tot_rd = g_trd[4:0]; tot_wr = g_twr[4:0]; tot_page_rd = g_tprd[4:0]; tot_page_wr = g_tpwr[2:0];
  endtask

  task automatic scramble();
    is_write = $urandom; page_mode = $urandom; mux_mode = $urandom;
    cs_sel = $urandom; lane_en = $urandom; addr_wait = $urandom;
    cs_wait = $urandom; rd_wait = $urandom; wr_wait = $urandom; wd_wait = $urandom;
    cs_hold = $urandom; wd_hold = $urandom;
    tot_rd = $urandom; tot_wr = $urandom; tot_page_rd = $urandom; tot_page_wr = $urandom;
  endtask

  task automatic zero_cfg();
    g_wr = 0; g_page = 0; g_mux = 0; g_sel = 0; g_lanes = 3; g_cs = 0; g_rd = 0;
    g_wrd = 0; g_wd = 0; g_cx = 0; g_wx = 0; g_aw = 0;
    g_trd = 0; g_twr = 0; g_tprd = 0; g_tpwr = 0;
  endtask

  task automatic pick_random();
    g_wr = $urandom % 2; g_page = $urandom % 2; g_mux = $urandom % 2; g_sel = $urandom % 4;
    g_lanes = $urandom % 4; g_cs = $urandom % 8; g_rd = $urandom % 8; g_wrd = $urandom % 8;
    g_wd = $urandom % 8; g_cx = $urandom % 8; g_wx = $urandom % 8; g_aw = $urandom % 4;
    g_trd = $urandom % 32; g_twr = $urandom % 32; g_tprd = $urandom % 32; g_tpwr = $urandom % 8;
  endtask

  task automatic pick_legal();
    int t, hi, lo, s;
    pick_random();
    t = e_total(); hi = imin(t, 7);
    if (hi < 2) g_mux = 0;
    if (g_mux) g_aw = $urandom % (imin(hi - 2, 3) + 1);
    lo = g_mux ? g_aw + 2 : 0;
    s = lo + $urandom % (hi - lo + 1);
    if (g_wr) begin g_wrd = s; g_wd = lo + $urandom % (s - lo + 1); end
    else g_rd = s;
    g_cs = g_mux ? $urandom % (g_aw + 1) : $urandom % (s + 1);
    g_cx = $urandom % (g_wx + 1);
  endtask

  task automatic check_step(input string tag, input int s, input int t, input int cse,
                            input int rde, input int wre, input int wde);
    bit main = (s <= t);
    int over = s - t;
    bit cs_on = (s >= cse) && (main || over <= g_cx);
    bit rd_on = !g_wr && main && (s >= rde);
    bit wr_on = g_wr && main && (s >= wre);
    bit wd_on = g_wr && (s >= wde) && (main || over <= g_wx);
    bit al_on = g_mux && main && (s < g_aw + 2);
    chk($sformatf("R2 cs_n %s step %0d", tag, s), cs_n, cs_on ? (~(4'b1 << g_sel) & 4'hF) : 4'hF);
    chk($sformatf("R3 rd_n %s step %0d", tag, s), rd_n, !rd_on);
    chk($sformatf("R4 wr_n %s step %0d", tag, s), wr_n, wr_on ? (~g_lanes[1:0] & 2'b11) : 2'b11);
    chk($sformatf("R5 wd_oe %s step %0d", tag, s), wd_oe, wd_on);
    chk($sformatf("R6 ale %s step %0d", tag, s), ale, al_on);
    chk($sformatf("R10 done early %s step %0d", tag, s), done, 0);
  endtask

  task automatic do_access(input string tag, input bit poke, input bit chain);
    int t = e_total(), n = e_steps();
    bit err = e_err();
    int cse = imin(g_cs, t), rde = imin(g_rd, t), wre = imin(g_wrd, t), wde = imin(g_wd, t);
    if (!pending) begin drive_cfg(); start = 1; end
    if (n < 3) poke = 0;
    @(negedge clk);
    chk($sformatf("R10 done at accept cycle %s", tag), done, pending);
    chk($sformatf("R10 idle at accept cycle %s", tag), {cs_n, rd_n, wr_n, wd_oe, ale}, 9'h1FC);
    chk($sformatf("R8 config_error %s", tag), config_error, err);
    start = 0;
    scramble();
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      check_step(tag, s, t, cse, rde, wre, wde);
      if (poke && s == 0) start = 1;
      if (poke && s == 1) start = 0;
      if (chain && s == n - 1) begin pick_legal(); drive_cfg(); start = 1; end
    end
    pending = chain;
    if (!chain) begin
      @(negedge clk);
      chk($sformatf("R10 done pulse %s", tag), done, 1);
      chk($sformatf("R10 idle with done %s", tag), {cs_n, rd_n, wr_n, wd_oe, ale}, 9'h1FC);
      chk($sformatf("R8 error held %s", tag), config_error, err);
      @(negedge clk);
      chk($sformatf("R10 done single %s", tag), done, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    zero_cfg(); drive_cfg();
    repeat (3) @(negedge clk);
    chk("R1 reset outputs held", {cs_n, rd_n, wr_n, wd_oe, ale, done, config_error}, 11'h7F0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs after release", {cs_n, rd_n, wr_n, wd_oe, ale, done, config_error}, 11'h7F0);

    zero_cfg(); do_access("zero waits read", 0, 0);
    zero_cfg(); g_wr = 1; g_page = 1; g_twr = 20; g_tpwr = 3; g_wrd = 2; g_wd = 1; g_cs = 1;
    g_wx = 2; g_cx = 1; g_sel = 2; do_access("R7 page write total", 0, 0);
    zero_cfg(); g_mux = 1; g_aw = 1; g_cs = 1; g_rd = 3; g_trd = 5; g_cx = 2; g_sel = 3;
    do_access("R6 mux read", 0, 0);
    zero_cfg(); g_cs = 6; g_rd = 7; g_trd = 2; do_access("R9 clamp read", 0, 0);
    zero_cfg(); g_mux = 1; g_aw = 0; g_cs = 2; g_rd = 4; g_trd = 9; do_access("R8 mux cs rule", 0, 0);
    zero_cfg(); g_wr = 1; g_twr = 6; g_wrd = 3; g_wd = 2; g_cs = 1; g_wx = 4; g_cx = 1;
    g_lanes = 2; do_access("R5 write hold lane1", 0, 0);
    zero_cfg(); g_wr = 1; g_twr = 4; g_wrd = 4; g_wd = 1; g_cx = 3; g_wx = 1;
    do_access("R8 hold rule", 0, 0);
    zero_cfg(); g_trd = 8; g_rd = 2; g_cx = 1; do_access("R11 ignored start", 1, 1);
    do_access("R10 chained", 1, 0);

    for (int i = 0; i < 150; i++) begin
      if (!pending) begin
        if ($urandom % 2) pick_legal(); else pick_random();
      end
      do_access($sformatf("rand %0d", i), ($urandom % 4) == 0, ($urandom % 4) == 0);
    end
    if (pending) do_access("final", 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule